// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This block sits between a UART's receive FIFO, its transmit path and the modem handshake lines. It carries out flow control without the CPU. In hardware mode it drives the ready-to-send line from the receive FIFO fill level, with separate halt and resume thresholds. It also lets the transmitter start a new character only while clear-to-send is high. In software mode it compares each received character with two programmable values, a pause character (Xoff) and a resume character (Xon). A matching character pauses or resumes host data and never reaches the data FIFO. The block also injects its own Xoff when the receive FIFO fills and one Xon once it drains.

The receiver presents one character per `rx_valid` pulse, and the unit forwards it one cycle later on `fifo_wr`/`fifo_wdata` when it is not a flow character. The host transmit queue shows its head byte on `tx_byte` and its state on `tx_avail`, and the unit pops it with `tx_pop`. The serializer reports `ser_busy` and takes a character on each `ser_load` pulse. Both modes have their own enables and may run together.

Top module: `afc_top`

## Requirements
- R1: After a synchronous reset, `rts_out` is 1, and `ser_load`, `tx_pop` and `fifo_wr` are 0.
- R2: With `hw_flow_en`=1, a fill level at or above `halt_level` makes `rts_out` 0 on the next clock edge.
- R3: With `hw_flow_en`=1, `rts_out` keeps its value while the fill level is at or above `resume_level` and below `halt_level`. It returns to 1 one edge after the level drops below `resume_level`.
- R4: With `hw_flow_en`=0, `rts_out` is 1 whatever the fill level, and `cts_in` has no effect on transmission.
- R5: With `hw_flow_en`=1 and `cts_in`=0, no new character is loaded, neither host data nor flow characters. A character already being shifted out is not affected.
- R6: With `sw_flow_en`=1, a received byte equal to `xon_char` or `xoff_char` is not written to the FIFO. Any other byte appears on `fifo_wdata` with `fifo_wr`=1 one cycle after `rx_valid`.
- R7: With `sw_flow_en`=1, a received `xoff_char` stops host bytes from being loaded, and a received `xon_char` allows them again. If both values are equal, the byte counts as Xoff.
- R8: With `sw_flow_en`=0, the Xon and Xoff values pass through as ordinary data and do not pause the transmitter.
- R9: With `sw_flow_en`=1, once the fill level reaches `halt_level`, exactly one `xoff_char` is loaded, ahead of any waiting host byte.
- R10: After that Xoff has been loaded, once the fill level is below `resume_level`, exactly one `xon_char` is loaded, ahead of host data.
- R11: Flow characters are loaded even while host data is paused by a received Xoff. They still obey the clear-to-send gate of R5.
- R12: `ser_load` is raised only for a cycle in which `ser_busy` was 0, and never in two consecutive cycles. `tx_pop` is raised only together with a host-byte load.
- R13: With both enables set, the threshold handshake and the in-band Xoff/Xon work at the same time on the same fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_flow_en | input | 1 | Enables threshold RTS and CTS gating |
| sw_flow_en | input | 1 | Enables in-band Xon/Xoff handling |
| xon_char | input | 8 | Resume character value |
| xoff_char | input | 8 | Pause character value |
| halt_level | input | LVL_W | Fill level that stops the remote sender |
| resume_level | input | LVL_W | Fill level below which the remote sender may resume |
| rx_fill_level | input | LVL_W | Current receive FIFO occupancy |
| cts_in | input | 1 | Clear-to-send, 1 = remote accepts data |
| rts_out | output | 1 | Ready-to-send, 1 = local receiver accepts data |
| rx_valid | input | 1 | A received character is present |
| rx_data | input | 8 | Received character |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_wdata | output | 8 | Data to the receive FIFO |
| tx_avail | input | 1 | Host transmit queue is not empty |
| tx_byte | input | 8 | Head byte of the host transmit queue |
| tx_pop | output | 1 | Removes the head byte of the host queue |
| ser_busy | input | 1 | Serializer is shifting a character |
| ser_load | output | 1 | Starts the serializer on `ser_char` |
| ser_char | output | 8 | Character handed to the serializer |

## Verification
A wrong internal state shows up at the ports within one or two clocks. A stuck pause flag either blocks `tx_pop` for good or lets host bytes through after an Xoff. A sequencer stuck in its pending states repeats an Xoff or Xon on `ser_load` as soon as the serializer goes idle. A wrong hysteresis register makes `rts_out` differ from the reference on the edge after a fill-level change. The bench model tracks these states with its own variables and compares every output on every clock, so a divergence is reported in the cycle it first appears.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int CHAR_W = 8;

    typedef logic [CHAR_W-1:0] char_t;

    // sequencer for the characters this side sends to its peer
    typedef enum logic [1:0] {
        LF_OPEN      = 2'd0,
        LF_XOFF_PEND = 2'd1,
        LF_XOFF_SENT = 2'd2,
        LF_XON_PEND  = 2'd3
    } lflow_e;

    typedef struct packed {
        logic  load;
        logic  pop;
        char_t ch;
    } tx_slot_t;

    function automatic logic is_flow_char(input char_t ch, input char_t on_c,
                                          input char_t off_c);
        return (ch == on_c) || (ch == off_c);
    endfunction

endpackage

// File: rtl/afc_rts_ctl.sv
module afc_rts_ctl #(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_en,
    input  logic [LVL_W-1:0] fill,
    input  logic [LVL_W-1:0] halt_lvl,
    input  logic [LVL_W-1:0] resume_lvl,
    output logic             rts
);
    logic rts_q;
    logic rts_d;

    always_comb begin
        rts_d = rts_q;
        if (!hw_en)                   rts_d = 1'b1;
        else if (fill >= halt_lvl)    rts_d = 1'b0;
        else if (fill <  resume_lvl)  rts_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) rts_q <= 1'b1;
        else     rts_q <= rts_d;
    end

    assign rts = rts_q;
endmodule

// File: rtl/afc_rx_filter.sv
module afc_rx_filter
    import afc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sw_en,
    input  char_t on_c,
    input  char_t off_c,
    input  logic  in_valid,
    input  char_t in_data,
    output logic  wr,
    output char_t wdata,
    output logic  hold
);
    logic  wr_q;
    char_t wdata_q;
    logic  hold_q;
    logic  swallow;

    assign swallow = sw_en && in_valid && is_flow_char(in_data, on_c, off_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            wdata_q <= '0;
            hold_q  <= 1'b0;
        end else begin
            wr_q <= in_valid && !swallow;
            if (in_valid) wdata_q <= in_data;
            if (!sw_en)
                hold_q <= 1'b0;
            else if (in_valid && in_data == off_c)
                hold_q <= 1'b1;
            else if (in_valid && in_data == on_c)
                hold_q <= 1'b0;
        end
    end

    assign wr    = wr_q;
    assign wdata = wdata_q;
    assign hold  = hold_q;
endmodule

// File: rtl/afc_local_flow.sv
module afc_local_flow
    import afc_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_en,
    input  logic [LVL_W-1:0] fill,
    input  logic [LVL_W-1:0] halt_lvl,
    input  logic [LVL_W-1:0] resume_lvl,
    input  logic             grant,
    output logic             req,
    output logic             req_is_on
);
    lflow_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!sw_en) begin
            st_d = LF_OPEN;
        end else begin
            case (st_q)
                LF_OPEN:      if (fill >= halt_lvl) st_d = LF_XOFF_PEND;
                LF_XOFF_PEND: if (grant)            st_d = LF_XOFF_SENT;
                              else if (fill < resume_lvl) st_d = LF_OPEN;
                LF_XOFF_SENT: if (fill < resume_lvl) st_d = LF_XON_PEND;
                LF_XON_PEND:  if (grant)            st_d = LF_OPEN;
                              else if (fill >= halt_lvl) st_d = LF_XOFF_SENT;
                default:      st_d = LF_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LF_OPEN;
        else     st_q <= st_d;
    end

    assign req       = sw_en && (st_q == LF_XOFF_PEND || st_q == LF_XON_PEND);
    assign req_is_on = (st_q == LF_XON_PEND);
endmodule

// File: rtl/afc_tx_arb.sv
module afc_tx_arb
    import afc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hw_en,
    input  logic  sw_en,
    input  logic  cts,
    input  logic  hold,
    input  logic  busy,
    input  logic  flow_req,
    input  logic  flow_is_on,
    input  char_t on_c,
    input  char_t off_c,
    input  logic  host_avail,
    input  char_t host_byte,
    output logic  flow_grant,
    output logic  load,
    output char_t ch,
    output logic  pop
);
    tx_slot_t slot_q, slot_d;
    logic     free_slot;
    logic     gate_ok;
    logic     host_grant;

    assign free_slot  = !busy && !slot_q.load;
    assign gate_ok    = !hw_en || cts;
    assign flow_grant = free_slot && gate_ok && flow_req;
    assign host_grant = free_slot && gate_ok && !flow_req && host_avail
                        && !(sw_en && hold);

    always_comb begin
        slot_d.load = flow_grant || host_grant;
        slot_d.pop  = host_grant;
        slot_d.ch   = flow_grant ? (flow_is_on ? on_c : off_c) : host_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign load = slot_q.load;
    assign pop  = slot_q.pop;
    assign ch   = slot_q.ch;
endmodule

// File: rtl/afc_top.sv
module afc_top
    import afc_pkg::*;
#(
    parameter  int FIFO_DEPTH = 32,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_flow_en,
    input  logic             sw_flow_en,
    input  logic [7:0]       xon_char,
    input  logic [7:0]       xoff_char,
    input  logic [LVL_W-1:0] halt_level,
    input  logic [LVL_W-1:0] resume_level,
    input  logic [LVL_W-1:0] rx_fill_level,
    input  logic             cts_in,
    output logic             rts_out,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             fifo_wr,
    output logic [7:0]       fifo_wdata,
    input  logic             tx_avail,
    input  logic [7:0]       tx_byte,
    output logic             tx_pop,
    input  logic             ser_busy,
    output logic             ser_load,
    output logic [7:0]       ser_char
);
    logic remote_hold;
    logic flow_req;
    logic flow_is_on;
    logic flow_grant;

    afc_rts_ctl #(.LVL_W(LVL_W)) rts_i (
        .clk(clk), .rst(rst), .hw_en(hw_flow_en), .fill(rx_fill_level),
        .halt_lvl(halt_level), .resume_lvl(resume_level), .rts(rts_out)
    );

    afc_rx_filter rxf_i (
        .clk(clk), .rst(rst), .sw_en(sw_flow_en), .on_c(xon_char),
        .off_c(xoff_char), .in_valid(rx_valid), .in_data(rx_data),
        .wr(fifo_wr), .wdata(fifo_wdata), .hold(remote_hold)
    );

    afc_local_flow #(.LVL_W(LVL_W)) lfl_i (
        .clk(clk), .rst(rst), .sw_en(sw_flow_en), .fill(rx_fill_level),
        .halt_lvl(halt_level), .resume_lvl(resume_level), .grant(flow_grant),
        .req(flow_req), .req_is_on(flow_is_on)
    );

    afc_tx_arb arb_i (
        .clk(clk), .rst(rst), .hw_en(hw_flow_en), .sw_en(sw_flow_en),
        .cts(cts_in), .hold(remote_hold), .busy(ser_busy),
        .flow_req(flow_req), .flow_is_on(flow_is_on), .on_c(xon_char),
        .off_c(xoff_char), .host_avail(tx_avail), .host_byte(tx_byte),
        .flow_grant(flow_grant), .load(ser_load), .ch(ser_char), .pop(tx_pop)
    );
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             hw_flow_en,
    input logic             sw_flow_en,
    input logic [7:0]       xon_char,
    input logic [7:0]       xoff_char,
    input logic [LVL_W-1:0] halt_level,
    input logic [LVL_W-1:0] resume_level,
    input logic [LVL_W-1:0] rx_fill_level,
    input logic             cts_in,
    input logic             rts_out,
    input logic             rx_valid,
    input logic [7:0]       rx_data,
    input logic             fifo_wr,
    input logic [7:0]       fifo_wdata,
    input logic             tx_pop,
    input logic             ser_busy,
    input logic             ser_load,
    input logic             remote_hold
);
    p_rts_halt_r2: assert property (@(posedge clk) disable iff (rst)
        (hw_flow_en && rx_fill_level >= halt_level) |=> !rts_out);

    p_rts_resume_r3: assert property (@(posedge clk) disable iff (rst)
        (hw_flow_en && rx_fill_level < resume_level && rx_fill_level < halt_level)
        |=> rts_out);

    p_rts_off_r4: assert property (@(posedge clk) disable iff (rst)
        !hw_flow_en |=> rts_out);

    p_cts_gate_r5: assert property (@(posedge clk) disable iff (rst)
        ser_load |-> $past(!hw_flow_en || cts_in));

    p_flow_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (sw_flow_en && rx_valid && (rx_data == xon_char || rx_data == xoff_char))
        |=> !fifo_wr);

    p_host_pause_r7: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> $past(!sw_flow_en || !remote_hold));

    p_pass_through_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !sw_flow_en) |=> (fifo_wr && fifo_wdata == $past(rx_data)));

    p_load_idle_r12: assert property (@(posedge clk) disable iff (rst)
        ser_load |-> $past(!ser_busy));

    p_load_spacing_r12: assert property (@(posedge clk) disable iff (rst)
        ser_load |=> !ser_load);

    p_pop_with_load_r12: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> ser_load);
endmodule

bind afc_top afc_checker #(.LVL_W(LVL_W)) chk_i (.*);

// File: tb/afc_top_tb_top.sv
module afc_top_tb_top;
    localparam int SER_LEN = 4;

    logic       clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       hw_flow_en = 0, sw_flow_en = 0;
    logic [7:0] xon_char = 8'h11, xoff_char = 8'h13;
    logic [5:0] halt_level = 6'd24, resume_level = 6'd8, rx_fill_level = 0;
    logic       cts_in = 1'b1;
    logic       rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic       tx_avail = 0;
    logic [7:0] tx_byte = 0;
    logic       ser_busy = 0;
    logic       rts_out, fifo_wr, tx_pop, ser_load;
    logic [7:0] fifo_wdata, ser_char;

    afc_top dut_i (.*);

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] hq[$];
    int bcnt = 0;
    int n_xoff = 0, n_xon = 0, n_pop = 0, n_wr = 0;

    // reference model state
    bit m_rts = 1, m_wr = 0, m_load = 0, m_pop = 0, m_hold = 0;
    logic [7:0] m_wdata = 0, m_char = 0;
    int m_st = 0; // 0 open, 1 owe Xoff, 2 Xoff out, 3 owe Xon

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit gate, slot, freq, fg, hg;
        logic [7:0] fch;
        if (rst) begin
            m_rts = 1; m_wr = 0; m_load = 0; m_pop = 0; m_hold = 0; m_st = 0;
            return;
        end
        gate = !hw_flow_en || cts_in;
        slot = !ser_busy && !m_load;
        freq = sw_flow_en && (m_st == 1 || m_st == 3);
        fch  = (m_st == 3) ? xon_char : xoff_char;
        fg   = slot && gate && freq;
        hg   = slot && gate && !freq && (hq.size() > 0) && !(sw_flow_en && m_hold);
        if (!sw_flow_en) m_st = 0;
        else case (m_st)
            0: if (rx_fill_level >= halt_level) m_st = 1;
            1: if (fg) m_st = 2; else if (rx_fill_level < resume_level) m_st = 0;
            2: if (rx_fill_level < resume_level) m_st = 3;
            default: if (fg) m_st = 0; else if (rx_fill_level >= halt_level) m_st = 2;
        endcase
        m_load = fg || hg;
        m_pop  = hg;
        if (m_load) m_char = fg ? fch : hq[0];
        if (!hw_flow_en) m_rts = 1;
        else if (rx_fill_level >= halt_level) m_rts = 0;
        else if (rx_fill_level < resume_level) m_rts = 1;
        m_wr = rx_valid && !(sw_flow_en && (rx_data == xon_char || rx_data == xoff_char));
        if (rx_valid) m_wdata = rx_data;
        if (!sw_flow_en) m_hold = 0;
        else if (rx_valid && rx_data == xoff_char) m_hold = 1;
        else if (rx_valid && rx_data == xon_char) m_hold = 0;
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R3", "rts_out", rts_out, m_rts);
        chk("R6", "fifo_wr", fifo_wr, m_wr);
        if (m_wr) chk("R6", "fifo_wdata", fifo_wdata, m_wdata);
        chk("R12", "ser_load", ser_load, m_load);
        if (m_load) chk("R9", "ser_char", ser_char, m_char);
        chk("R7", "tx_pop", tx_pop, m_pop);
        if (ser_load && ser_char == xoff_char) n_xoff++;
        if (ser_load && ser_char == xon_char) n_xon++;
        if (tx_pop) n_pop++;
        if (fifo_wr) n_wr++;
        if (m_load) bcnt = SER_LEN; else if (bcnt > 0) bcnt--;
        ser_busy = (bcnt != 0);
        if (m_pop && hq.size() > 0) void'(hq.pop_front());
        tx_avail = hq.size() > 0;
        tx_byte  = (hq.size() > 0) ? hq[0] : 8'h00;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic push(logic [7:0] b);
        hq.push_back(b);
        tx_avail = 1;
        tx_byte  = hq[0];
    endtask

    task automatic rx_send(logic [7:0] b);
        rx_valid = 1; rx_data = b; cyc();
        rx_valid = 0; cyc();
    endtask

    task automatic clr();
        n_xoff = 0; n_xon = 0; n_pop = 0; n_wr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired act=hung exp=finished");
        finish_run();
    end

    initial begin
        // R1 reset state
        run(3);
        chk("R1", "rts after reset", rts_out, 1);
        chk("R1", "load after reset", ser_load, 0);
        rst = 0;
        cyc();

        // R4 hardware mode off: full FIFO and CTS low do nothing
        clr(); rx_fill_level = 31; cts_in = 0;
        push(8'hA1); push(8'hA2); push(8'hA3);
        run(20);
        chk("R4", "pops with cts ignored", n_pop, 3);
        chk("R4", "rts stays high", rts_out, 1);

        // R2 and R3 threshold hysteresis
        hw_flow_en = 1; cts_in = 1; rx_fill_level = 0; cyc();
        for (int f = 0; f <= 31; f++) begin rx_fill_level = 6'(f); cyc(); end
        chk("R2", "rts low at full", rts_out, 0);
        for (int f = 31; f >= 8; f--) begin rx_fill_level = 6'(f); cyc(); end
        chk("R3", "rts held at resume level", rts_out, 0);
        rx_fill_level = 7; cyc(); cyc();
        chk("R3", "rts back below resume", rts_out, 1);

        // R5 CTS gating
        clr(); cts_in = 0; push(8'hB1); push(8'hB2);
        run(15);
        chk("R5", "no load while cts low", n_pop, 0);
        cts_in = 1; cyc(); cyc(); cts_in = 0;
        run(10);
        chk("R5", "one byte then stop", n_pop, 1);
        cts_in = 1; run(10);
        chk("R5", "rest after cts", n_pop, 2);

        // R6 and R7 in-band receive handling
        hw_flow_en = 0; sw_flow_en = 1; rx_fill_level = 0; cyc();
        clr();
        rx_send(8'h41); rx_send(8'h13); rx_send(8'h42);
        chk("R6", "flow char dropped", n_wr, 2);
        push(8'hC1); push(8'hC2); run(15);
        chk("R7", "paused after xoff", n_pop, 0);
        rx_send(8'h11); run(15);
        chk("R7", "resumed after xon", n_pop, 2);
        chk("R6", "xon dropped", n_wr, 2);

        // R8 software mode off
        sw_flow_en = 0; cyc(); clr();
        rx_send(8'h13); rx_send(8'h11);
        chk("R8", "flow values stored", n_wr, 2);
        rx_send(8'h13); push(8'hD1); run(10);
        chk("R8", "no pause", n_pop, 1);

        // R9 R10 R11 local Xoff/Xon with remote pause active
        sw_flow_en = 1; cyc(); rx_send(8'h13); clr();
        push(8'hE1); push(8'hE2);
        for (int f = 10; f <= 30; f++) begin rx_fill_level = 6'(f); cyc(); end
        run(10);
        chk("R9", "single xoff", n_xoff, 1);
        chk("R11", "host still paused", n_pop, 0);
        for (int f = 30; f >= 3; f--) begin rx_fill_level = 6'(f); cyc(); end
        run(10);
        chk("R10", "single xon", n_xon, 1);
        rx_send(8'h11); run(15);
        chk("R7", "host drained", n_pop, 2);

        // R13 both modes, R11 flow char waits for CTS
        hw_flow_en = 1; cts_in = 0; clr();
        for (int f = 3; f <= 28; f++) begin rx_fill_level = 6'(f); cyc(); end
        run(10);
        chk("R13", "rts low", rts_out, 0);
        chk("R11", "xoff held by cts", n_xoff, 0);
        cts_in = 1; run(10);
        chk("R13", "xoff after cts", n_xoff, 1);
        for (int f = 28; f >= 2; f--) begin rx_fill_level = 6'(f); cyc(); end
        run(10);
        chk("R13", "xon sent", n_xon, 1);
        chk("R13", "rts high", rts_out, 1);

        // R1 reset again mid-traffic
        push(8'hF1); rst = 1; run(2);
        chk("R1", "fifo_wr in reset", fifo_wr, 0);
        chk("R1", "pop in reset", tx_pop, 0);
        rst = 0; run(10);
        finish_run();
    end
endmodule